// File: doc/BRIEF.md
# Multi-Channel Event Timer

This block is a memory-mapped event timer. One free-running main counter advances by one on every clock while the global enable is set. A parameterised number of comparator channels (three by default) watch it. When a channel's comparator equals the counter on a counting cycle, the channel fires. It can then set its interrupt status bit and drive one of 32 interrupt lines. The line either carries a one-cycle pulse or stays high until software clears the status bit.

Software reaches every register through a plain 32-bit port: address, write enable, write data, and read data decoded without a clock. A channel can fire once (one-shot), or it can advance its comparator by a reload period on each match (periodic). A channel loads its first match time and its period through a two-write handshake. A legacy routing mode takes over the first two channels and sends them to lines 0 and 8.

Top module: `evt_timer_top`

## Requirements
- R1: The capability word at 0x000 reads a vendor code in bits 31:16, the channel count minus one in bits 12:8, and a revision code in bits 7:0. Bit 15 is 1 (legacy routing available) and bit 13 is 0 (the counter is not 64 bits wide).
- R2: The word at 0x004 returns the counter tick period in femtoseconds. It is nonzero and no greater than 100,000,000, which is at least 10 MHz.
- R3: Bit 0 of the global configuration at 0x010 is the counter enable. While it is set, the counter at 0x0F0 rises by one each clock. While it is clear, the counter holds its value. After reset the counter and the configuration are zero.
- R4: A write to the counter at 0x0F0 loads the value only while the enable is clear. While the enable is set, the write is ignored.
- R5: A channel matches on the first clock edge at which the counter is enabled and equals that channel's comparator. Channel n's configuration is at 0x100+0x20·n and its comparator is at 0x108+0x20·n. The status bit n at 0x020 is set on a match only if the interrupt-enable bit 2 is set. If bit 2 is clear, nothing is raised.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R7: In a channel configuration write, setting value-set bit 6 together with periodic bit 3 arms a handshake. The next comparator write sets the match value and the write after that sets the period. Bit 6 reads as 1 while the handshake is pending and as 0 once the period has been written.
- R8: On each match, a periodic channel adds its period to its comparator. A one-shot channel keeps its comparator unchanged.
- R9: Bit 4 of the channel configuration reads 1 only on periodic-capable channels (channels 0 and 1 by default). On any other channel, a write of bit 3 or bit 6 is ignored: both read back as 0 and the channel runs one-shot.
- R10: The word at 0x104+0x20·n is a read-only mask of the lines channel n may drive. A route value in bits 13:9 whose mask bit is clear drives no line.
- R11: While legacy bit 1 of the global configuration is set, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R12: With level bit 1 set, the routed line stays high while the status bit is set. Otherwise the line pulses for exactly one clock per match, in the same cycle the status bit becomes set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_line | output | 32 | Interrupt lines |

## Verification
The assertions assume that at most one register is written per cycle and that the address stays stable during a write. The bench follows this by driving writes one at a time from a task on the falling edge. The checks also assume that a comparator is never written in the same cycle in which it matches. The bench stops the counter before reprogramming, so no comparator update can collide with a match. The periodic checks assume a nonzero period, and the bench always programs small nonzero periods.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
   localparam int REG_W     = 32;
   localparam int ROUTE_W   = 5;
   localparam int NUM_LINES = 1 << ROUTE_W;

   // channel configuration bit positions
   localparam int B_LEVEL = 1;
   localparam int B_IE    = 2;
   localparam int B_TYPE  = 3;
   localparam int B_VSET  = 6;
   localparam int B_F32   = 8;
   localparam int B_ROUTE = 9;

   // register map
   localparam int A_CAP     = 'h000;
   localparam int A_PERIOD  = 'h004;
   localparam int A_GCFG    = 'h010;
   localparam int A_STATUS  = 'h020;
   localparam int A_COUNT   = 'h0F0;
   localparam int A_CH_BASE = 'h100;
   localparam int CH_STRIDE = 'h20;
   localparam int OFF_CFG   = 'h0;
   localparam int OFF_MASK  = 'h4;
   localparam int OFF_CMP   = 'h8;

   typedef enum logic [1:0] {VS_IDLE, VS_CMP, VS_PER} vset_phase_t;
endpackage

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (en)       cnt <= cnt + 1'b1;
      else if (ld)       cnt <= ld_val;
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ld) |=> $stable(cnt));
   assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> cnt == $past(cnt) + 1'b1);
   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && ld) |=> cnt == $past(ld_val));
endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
   import evt_timer_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit PER_CAP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [CNT_W-1:0]   cnt,
   input  logic               cfg_we,
   input  logic [REG_W-1:0]   cfg_wdata,
   input  logic               cmp_we,
   input  logic [CNT_W-1:0]   cmp_wdata,
   input  logic               st_clr,
   output logic [REG_W-1:0]   cfg_rd,
   output logic [CNT_W-1:0]   cmp_q,
   output logic               status,
   output logic               drive,
   output logic [ROUTE_W-1:0] route
);
   logic             int_en, level, periodic, f32;
   logic             pulse;
   logic [CNT_W-1:0] per_q;
   vset_phase_t      phase;
   logic             hit;

   assign hit = tick && (cnt == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_en   <= 1'b0;
         level    <= 1'b0;
         periodic <= 1'b0;
         f32      <= 1'b0;
         route    <= '0;
      end else if (cfg_we) begin
         int_en   <= cfg_wdata[B_IE];
         level    <= cfg_wdata[B_LEVEL];
         periodic <= cfg_wdata[B_TYPE] & PER_CAP;
         f32      <= cfg_wdata[B_F32];
         route    <= cfg_wdata[B_ROUTE +: ROUTE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= VS_IDLE;
         cmp_q <= '1;
         per_q <= '0;
      end else if (cfg_we && PER_CAP && cfg_wdata[B_VSET] && cfg_wdata[B_TYPE]) begin
         phase <= VS_CMP;
      end else if (cmp_we) begin
         unique case (phase)
            VS_CMP: begin
               cmp_q <= cmp_wdata;
               phase <= VS_PER;
            end
            VS_PER: begin
               per_q <= cmp_wdata;
               phase <= VS_IDLE;
            end
            default: begin
               cmp_q <= cmp_wdata;
               if (periodic) per_q <= cmp_wdata;
            end
         endcase
      end else if (hit && periodic) begin
         cmp_q <= cmp_q + per_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= 1'b0;
         pulse  <= 1'b0;
      end else begin
         if (hit && int_en)  status <= 1'b1;
         else if (st_clr)    status <= 1'b0;
         pulse <= hit && int_en && !level;
      end
   end

   assign drive = level ? status : pulse;

   assign cfg_rd = {{(REG_W-B_ROUTE-ROUTE_W){1'b0}}, route, f32, 1'b0,
                    (phase != VS_IDLE), 1'b0, PER_CAP, periodic, int_en, level, 1'b0};

   assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && int_en) |=> status);
   assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!status && !(hit && int_en)) |=> !status);
   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_clr && !(hit && int_en)) |=> !status);
   assert_oneshot_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !periodic && !cmp_we && !cfg_we) |=> $stable(cmp_q));
   assert_periodic_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && periodic && !cmp_we && !cfg_we) |=> cmp_q == $past(cmp_q) + $past(per_q));
   generate
      if (!PER_CAP) begin : g_no_per
         assert_type_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we |=> (!periodic && phase == VS_IDLE));
      end
   endgenerate
endmodule

// File: rtl/evt_timer_router.sv
module evt_timer_router
   import evt_timer_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         legacy_on,
   input  logic [NUM_CH-1:0]            drive,
   input  logic [NUM_CH*ROUTE_W-1:0]    route_flat,
   input  logic [NUM_CH*NUM_LINES-1:0]  mask_flat,
   output logic [NUM_LINES-1:0]         line
);
   localparam int LEG_LINE0 = 0;
   localparam int LEG_LINE1 = 8;

   always_comb begin
      line = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (legacy_on && c < 2) begin
            if (drive[c]) line[(c == 0) ? LEG_LINE0 : LEG_LINE1] = 1'b1;
         end else if (drive[c] &&
                      mask_flat[c*NUM_LINES + int'(route_flat[c*ROUTE_W +: ROUTE_W])]) begin
            line[route_flat[c*ROUTE_W +: ROUTE_W]] = 1'b1;
         end
      end
   end

   assert_legacy_ch0_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_on && drive[0]) |-> line[LEG_LINE0]);
   assert_legacy_ch1_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_on && drive[1]) |-> line[LEG_LINE1]);
   assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (drive == '0) |-> (line == '0));
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
   import evt_timer_pkg::*;
#(
   parameter int                       ADDR_W       = 12,
   parameter int                       CNT_W        = 32,
   parameter int                       NUM_CH       = 3,
   parameter int                       PERIOD_FS    = 10_000_000,
   parameter logic [15:0]              VENDOR_CODE  = 16'h1A2B,
   parameter logic [7:0]               REV_CODE     = 8'h01,
   parameter logic [NUM_CH-1:0]        PER_CAP_MASK = 3'b011,
   parameter logic [NUM_CH*32-1:0]     ROUTE_MASKS  = {32'h0000_0300, 32'h0000_00C0, 32'h0000_0030}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [31:0]       irq_line
);
   localparam int LAST_ADDR = A_CH_BASE + CH_STRIDE*NUM_CH - 1;

   generate
      if (NUM_CH < 2 || NUM_CH > 24) begin : g_bad_ch
         $error("NUM_CH must lie in 2..24");
      end
      if (PERIOD_FS <= 0 || PERIOD_FS > 100_000_000) begin : g_bad_per
         $error("PERIOD_FS must be nonzero and give at least 10 MHz");
      end
      if (CNT_W < 8 || CNT_W > REG_W) begin : g_bad_cw
         $error("CNT_W must lie in 8..32");
      end
      if ((1 << ADDR_W) <= LAST_ADDR) begin : g_bad_aw
         $error("ADDR_W too narrow for channel window");
      end
   endgenerate

   logic                      g_en, g_leg;
   logic [CNT_W-1:0]          cnt;
   logic [NUM_CH-1:0]         st, drv;
   logic [NUM_CH*ROUTE_W-1:0] route_flat;
   logic [REG_W-1:0]          ch_cfg [NUM_CH];
   logic [CNT_W-1:0]          ch_cmp [NUM_CH];
   logic                      wr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g_en  <= 1'b0;
         g_leg <= 1'b0;
      end else if (reg_we && reg_addr == ADDR_W'(A_GCFG)) begin
         g_en  <= reg_wdata[0];
         g_leg <= reg_wdata[1];
      end
   end

   assign wr_cnt = reg_we && reg_addr == ADDR_W'(A_COUNT);

   evt_timer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(g_en), .ld(wr_cnt),
      .ld_val(reg_wdata[CNT_W-1:0]), .cnt(cnt)
   );

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         localparam int BASE = A_CH_BASE + CH_STRIDE*n;
         logic [ROUTE_W-1:0] rt;
         evt_timer_channel #(.CNT_W(CNT_W), .PER_CAP(PER_CAP_MASK[n])) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (g_en),
            .cnt       (cnt),
            .cfg_we    (reg_we && reg_addr == ADDR_W'(BASE + OFF_CFG)),
            .cfg_wdata (reg_wdata),
            .cmp_we    (reg_we && reg_addr == ADDR_W'(BASE + OFF_CMP)),
            .cmp_wdata (reg_wdata[CNT_W-1:0]),
            .st_clr    (reg_we && reg_addr == ADDR_W'(A_STATUS) && reg_wdata[n]),
            .cfg_rd    (ch_cfg[n]),
            .cmp_q     (ch_cmp[n]),
            .status    (st[n]),
            .drive     (drv[n]),
            .route     (rt)
         );
         assign route_flat[n*ROUTE_W +: ROUTE_W] = rt;
      end
   endgenerate

   evt_timer_router #(.NUM_CH(NUM_CH)) u_rt (
      .clk(clk), .rst_n(rst_n), .legacy_on(g_leg), .drive(drv),
      .route_flat(route_flat), .mask_flat(ROUTE_MASKS), .line(irq_line)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_CAP))
         reg_rdata = {VENDOR_CODE, 1'b1, 1'b0, 1'b0, 5'(NUM_CH-1), REV_CODE};
      else if (reg_addr == ADDR_W'(A_PERIOD))
         reg_rdata = 32'(PERIOD_FS);
      else if (reg_addr == ADDR_W'(A_GCFG))
         reg_rdata = {30'd0, g_leg, g_en};
      else if (reg_addr == ADDR_W'(A_STATUS))
         reg_rdata = 32'(st);
      else if (reg_addr == ADDR_W'(A_COUNT))
         reg_rdata = 32'(cnt);
      for (int n = 0; n < NUM_CH; n++) begin
         if (reg_addr == ADDR_W'(A_CH_BASE + CH_STRIDE*n + OFF_CFG))  reg_rdata = ch_cfg[n];
         if (reg_addr == ADDR_W'(A_CH_BASE + CH_STRIDE*n + OFF_MASK)) reg_rdata = ROUTE_MASKS[n*32 +: 32];
         if (reg_addr == ADDR_W'(A_CH_BASE + CH_STRIDE*n + OFF_CMP))  reg_rdata = 32'(ch_cmp[n]);
      end
   end
endmodule

// File: tb/evt_timer_top_tb.sv
module evt_timer_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] irq_line;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   evt_timer_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_line(irq_line)
   );

   localparam logic [31:0] IE = 32'h4, LVL = 32'h2, TYP = 32'h8, VS = 32'h40;
   function automatic logic [11:0] cfg_a(int n); return 12'(32'h100 + 32*n); endfunction
   function automatic logic [11:0] cmp_a(int n); return 12'(32'h108 + 32*n); endfunction
   function automatic logic [31:0] rte(int l); return 32'(l) << 9; endfunction

   task automatic tick(int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask
   task automatic wr(logic [11:0] a, logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_we = 1'b0;
   endtask
   task automatic rd(logic [11:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask
   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask
   task automatic wait_line(int l, output int k);
      k = 0;
      while (k < 60 && !irq_line[l]) begin tick(1); k++; end
   endtask
   task automatic wait_stat(int ch, output int k);
      logic [31:0] v;
      k = 0;
      rd(12'h020, v);
      while (k < 60 && !v[ch]) begin tick(1); k++; rd(12'h020, v); end
   endtask
   task automatic quiet();
      wr(12'h010, 32'h0);
      for (int c = 0; c < 3; c++) wr(cfg_a(c), 32'h0);
      wr(12'h020, 32'h7);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v2;
      int k;
      int line_of [3];
      line_of[0] = 4; line_of[1] = 6; line_of[2] = 8;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(12'h0F0, v); chk("R3 reset counter", v, 0);
      rd(12'h010, v); chk("R3 reset gcfg", v, 0);
      rd(12'h020, v); chk("R5 reset status", v, 0);
      chk("R12 reset lines", irq_line, 0);

      // capability and period
      rd(12'h000, v);
      chk("R1 vendor", {16'h0, v[31:16]}, 32'h1A2B);
      chk("R1 count-1", {27'h0, v[12:8]}, 2);
      chk("R1 rev", {24'h0, v[7:0]}, 1);
      chk("R1 legacy flag", {31'h0, v[15]}, 1);
      chk("R1 width flag", {31'h0, v[13]}, 0);
      rd(12'h004, v); chk("R2 period fs", v, 10_000_000);

      // counter hold, load, run
      tick(5); rd(12'h0F0, v); chk("R3 hold while disabled", v, 0);
      wr(12'h0F0, 100); rd(12'h0F0, v); chk("R4 load while disabled", v, 100);
      wr(12'h010, 1); rd(12'h0F0, v); chk("R3 first enabled edge", v, 100);
      tick(7); rd(12'h0F0, v); chk("R3 count rate", v, 107);
      wr(12'h0F0, 5); rd(12'h0F0, v); chk("R4 write ignored while enabled", v, 108);
      wr(12'h010, 0); rd(12'h0F0, v); chk("R3 stop", v, 109);
      tick(4); rd(12'h0F0, v); chk("R3 stays stopped", v, 109);

      // match-delay sweep over channels and distances (edge type)
      for (int ch = 0; ch < 3; ch++) begin
         for (int di = 0; di < 4; di++) begin
            int delta;
            delta = (di == 3) ? 7 : di + 1;
            quiet();
            wr(12'h0F0, 32'(1000*ch + 37*di));
            wr(cmp_a(ch), 32'(1000*ch + 37*di + delta));
            wr(cfg_a(ch), IE | rte(line_of[ch]));
            wr(12'h010, 1);
            wait_line(line_of[ch], k);
            chk($sformatf("R5 ch%0d delay %0d", ch, delta), k, delta + 1);
            rd(12'h020, v); chk("R5 status bit set", v, 32'(1 << ch));
            tick(1);
            chk("R12 edge pulse one cycle", {31'h0, irq_line[line_of[ch]]}, 0);
         end
      end

      // status write-one-to-clear (ch2 still set)
      wr(12'h010, 0);
      wr(12'h020, 0); rd(12'h020, v); chk("R6 write zero keeps", v, 4);
      wr(12'h020, 4); rd(12'h020, v); chk("R6 write one clears", v, 0);

      // interrupt enable clear: nothing raised
      quiet();
      wr(12'h0F0, 0); wr(cmp_a(0), 3); wr(cfg_a(0), rte(4));
      wr(12'h010, 1); tick(8);
      rd(12'h020, v); chk("R5 no status without enable", v, 0);
      chk("R5 no line without enable", irq_line, 0);

      // level type holds until cleared
      quiet();
      wr(12'h0F0, 0); wr(cmp_a(1), 2); wr(cfg_a(1), IE | LVL | rte(6));
      wr(12'h010, 1);
      wait_line(6, k); chk("R12 level delay", k, 3);
      tick(5); chk("R12 level held", {31'h0, irq_line[6]}, 1);
      wr(12'h020, 2); chk("R12 level drops on clear", {31'h0, irq_line[6]}, 0);

      // periodic handshake on ch0
      quiet();
      wr(12'h0F0, 0);
      wr(cfg_a(0), IE | TYP | VS | rte(4));
      rd(cfg_a(0), v); chk("R7 handshake pending", {31'h0, v[6]}, 1);
      wr(cmp_a(0), 10);
      rd(cfg_a(0), v); chk("R7 still pending", {31'h0, v[6]}, 1);
      wr(cmp_a(0), 6);
      rd(cfg_a(0), v); chk("R7 self-cleared", {31'h0, v[6]}, 0);
      rd(cmp_a(0), v); chk("R7 match value kept", v, 10);
      wr(12'h010, 1);
      wait_line(4, k); chk("R8 first periodic match", k, 11);
      rd(cmp_a(0), v); chk("R8 comparator advanced", v, 16);
      for (int r = 0; r < 3; r++) begin
         tick(1); wait_line(4, k);
         chk("R8 period spacing", k + 1, 6);
      end
      rd(cmp_a(0), v); chk("R8 comparator after repeats", v, 34);

      // non-capable channel stays one-shot
      quiet();
      wr(cfg_a(2), IE | TYP | VS | rte(8));
      rd(cfg_a(2), v);
      chk("R9 type reads 0", {31'h0, v[3]}, 0);
      chk("R9 value-set reads 0", {31'h0, v[6]}, 0);
      chk("R9 capability flag 0", {31'h0, v[4]}, 0);
      rd(cfg_a(0), v2); chk("R9 capability flag 1 on ch0", {31'h0, v2[4]}, 1);
      wr(12'h0F0, 0); wr(cmp_a(2), 5); wr(cmp_a(2), 9);
      wr(12'h010, 1);
      wait_line(8, k); chk("R9 one-shot match", k, 10);
      tick(3); rd(cmp_a(2), v); chk("R8 one-shot comparator fixed", v, 9);

      // route masks and gating
      rd(12'h104, v); chk("R10 mask ch0", v, 32'h30);
      rd(12'h124, v); chk("R10 mask ch1", v, 32'hC0);
      rd(12'h144, v); chk("R10 mask ch2", v, 32'h300);
      quiet();
      wr(12'h0F0, 0); wr(cmp_a(0), 2); wr(cfg_a(0), IE | rte(9));
      wr(12'h010, 1);
      wait_stat(0, k); chk("R10 status still set", k, 3);
      chk("R10 disallowed route silent", irq_line, 0);

      // legacy routing
      quiet();
      wr(12'h0F0, 0); wr(cmp_a(0), 3); wr(cmp_a(1), 3);
      wr(cfg_a(0), IE | rte(4)); wr(cfg_a(1), IE | LVL | rte(6));
      wr(12'h010, 3);
      wait_line(0, k); chk("R11 ch0 on line 0", k, 4);
      chk("R11 ch1 on line 8", {31'h0, irq_line[8]}, 1);
      chk("R11 route fields bypassed", {30'h0, irq_line[6], irq_line[4]}, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule